// File: doc/BRIEF.md
# Dual-Channel DDR Lane Formatter

This block turns one sample from each of two converter channels (A and B) into a double-data-rate lane stream. It has twelve data lanes and a forwarded data clock. Each period of the forwarded clock carries two words. The first-phase word is driven while the clock is high and the second-phase word while it is low. A single mode input chooses how the sample bits are spread over the lanes.

In shared-lane mode, every lane carries one bit position of both channels: channel A in the first phase and channel B in the second. In split-lane mode, the lower six lanes belong to channel A and the upper six to channel B. Each lane carries an even bit in the first phase and the following odd bit in the second.

The block runs on a bit clock at twice the sample rate. Each period of the forwarded clock spans two bit-clock cycles. The two samples and the mode are captured together at every period boundary. The lane words are also exposed as ports so that a downstream serializer can be used in place of the built-in mux stage.

Top module: `ddr_lane_formatter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rise_word`, `fall_word`, `lane_out` and `dco` are all zero after that edge, and the captured mode is shared-lane (mode value 0).
- R2: With mode value 0 (shared-lane), `rise_word[n]` equals channel A bit n and `fall_word[n]` equals channel B bit n, for n = 0..11.
- R3: With mode value 1 (split-lane), for k = 0..5, `rise_word[k]` is A bit 2k, `fall_word[k]` is A bit 2k+1, `rise_word[6+k]` is B bit 2k and `fall_word[6+k]` is B bit 2k+1.
- R4: `samp_a`, `samp_b` and `mode_sel` are captured on the same edge. That edge is the first edge after reset release and every second edge after it. Values present at the other edges have no effect, and both words stay unchanged for the two cycles between captures.
- R5: `dco` is 1 after the edge that follows a capture edge, and 0 after each capture edge. Each level therefore lasts exactly one bit-clock cycle.
- R6: `lane_out` equals the period's `rise_word` while `dco` is 1, and the same period's `fall_word` in the following cycle while `dco` is 0.
- R7: A change on `mode_sel` takes effect only at a capture edge, so both halves of one `dco` period always use the same mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, twice the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Lane mapping: 0 shared-lane, 1 split-lane |
| samp_a | input | 12 | Channel A sample |
| samp_b | input | 12 | Channel B sample |
| rise_word | output | 12 | First-phase lane word of the current period |
| fall_word | output | 12 | Second-phase lane word of the current period |
| dco | output | 1 | Forwarded data clock |
| lane_out | output | 12 | DDR lane values |

## Verification
The words on `rise_word` and `fall_word` are due just after the capture edge. The bench drives inputs on falling edges and samples those words at the next falling edge. `dco` high and the first-phase `lane_out` follow one bit-clock cycle later. `dco` low and the second-phase `lane_out` come one cycle after that, which coincides with the next capture. The bench therefore checks the previous period's second phase together with the next capture. Between the capture and the following edge, the bench drives scrambled inputs and an inverted mode. This shows that off-boundary edges are ignored and that no period mixes mappings.

// File: rtl/ddr_fmt_pkg.sv
`timescale 1ns/1ps
// Package: ddr_fmt_pkg
// Shared types for the dual-channel DDR lane formatter.
// Assumes the sample width is even, so that bit pairs fill whole lanes.
package ddr_fmt_pkg;

    // Lane mapping selector; value 0 is the mapping held through reset.
    typedef enum logic {
        MAP_SHARED = 1'b0,   // one bit position per lane, A then B
        MAP_SPLIT  = 1'b1    // one lane group per channel, even then odd bit
    } map_mode_e;

endpackage

// File: rtl/ddr_phase_ctrl.sv
`timescale 1ns/1ps
// Module: ddr_phase_ctrl
// Tracks which half of a forwarded-clock period the next bit-clock edge
// belongs to. cap_en is high for the edge that opens a new period.
// Assumes a synchronous active-low reset; the first edge after release
// opens a period.
module ddr_phase_ctrl (
    input  logic clk,
    input  logic rst_n,
    output logic cap_en,
    output logic first_half
);

    logic phase_q;

    // Purpose: toggle the half-period marker on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    // Purpose: decode the boundary and first-phase strobes.
    always_comb begin
        cap_en     = ~phase_q;
        first_half = phase_q;
    end

    // R4: capture edges alternate with non-capture edges
    a_r4_capture_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> !cap_en);

endmodule

// File: rtl/sample_capture.sv
`timescale 1ns/1ps
// Module: sample_capture
// Registers both channel samples and the mode select on the same edge,
// and only at a period boundary. Everything downstream therefore belongs
// to one sampling instant and one mapping.
// Assumes cap_en is high on every second edge.
module sample_capture
    import ddr_fmt_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic [SAMPLE_W-1:0] samp_a,
    input  logic [SAMPLE_W-1:0] samp_b,
    input  logic                mode_sel,
    output logic [SAMPLE_W-1:0] a_q,
    output logic [SAMPLE_W-1:0] b_q,
    output map_mode_e           mode_q
);

    // Purpose: take both samples and the mapping together at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            mode_q <= MAP_SHARED;
        end else if (cap_en) begin
            a_q    <= samp_a;
            b_q    <= samp_b;
            mode_q <= map_mode_e'(mode_sel);
        end
    end

    // R4: samples are untouched by non-boundary edges
    a_r4_samples_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(a_q) && $stable(b_q)));

    // R7: mapping only changes at a boundary
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(mode_q));

endmodule

// File: rtl/lane_mapper.sv
`timescale 1ns/1ps
// Module: lane_mapper
// Builds the first-phase and second-phase lane words from the captured
// samples. Both mappings are built in parallel and the captured mode
// picks one of them.
// Assumes SAMPLE_W is even; lane count equals the sample width.
module lane_mapper
    import ddr_fmt_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic [SAMPLE_W-1:0] a_q,
    input  logic [SAMPLE_W-1:0] b_q,
    input  map_mode_e           mode_q,
    output logic [SAMPLE_W-1:0] rise_word,
    output logic [SAMPLE_W-1:0] fall_word
);

    localparam int LANES     = SAMPLE_W;
    localparam int GRP_LANES = LANES / 2;

    logic [LANES-1:0] sh_rise, sh_fall;
    logic [LANES-1:0] sp_rise, sp_fall;

    // Shared-lane mapping: lane n carries bit n of A, then bit n of B.
    for (genvar n = 0; n < LANES; n++) begin : g_shared
        assign sh_rise[n] = a_q[n];
        assign sh_fall[n] = b_q[n];
    end

    // Split-lane mapping: A on the lower group, B on the upper group,
    // even bit in the first phase and odd bit in the second.
    for (genvar k = 0; k < GRP_LANES; k++) begin : g_split
        assign sp_rise[k]             = a_q[2*k];
        assign sp_fall[k]             = a_q[2*k+1];
        assign sp_rise[GRP_LANES + k] = b_q[2*k];
        assign sp_fall[GRP_LANES + k] = b_q[2*k+1];
    end

    // Purpose: pick the active mapping.
    always_comb begin
        if (mode_q == MAP_SPLIT) begin
            rise_word = sp_rise;
            fall_word = sp_fall;
        end else begin
            rise_word = sh_rise;
            fall_word = sh_fall;
        end
    end

endmodule

// File: rtl/ddr_lane_mux.sv
`timescale 1ns/1ps
// Module: ddr_lane_mux
// Synchronous DDR output stage. On the edge after a capture it drives the
// first-phase word and raises dco. On the next edge it drives the
// second-phase word and lowers dco. Each level lasts one bit-clock cycle.
// Assumes the words are stable for the whole period.
module ddr_lane_mux #(
    parameter int LANES = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_half,
    input  logic [LANES-1:0] rise_word,
    input  logic [LANES-1:0] fall_word,
    output logic [LANES-1:0] lane_out,
    output logic             dco
);

    // Purpose: register the phase word and the forwarded clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_out <= '0;
            dco      <= 1'b0;
        end else if (first_half) begin
            lane_out <= rise_word;
            dco      <= 1'b1;
        end else begin
            lane_out <= fall_word;
            dco      <= 1'b0;
        end
    end

    // R5: dco high lasts exactly one cycle
    a_r5_dco_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dco |=> !dco);

    // R6: first-phase word appears with dco high
    a_r6_rise_lane: assert property (@(posedge clk) disable iff (!rst_n)
        first_half |=> (dco && lane_out == $past(rise_word)));

    // R6: second-phase word appears with dco low
    a_r6_fall_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !first_half |=> (!dco && lane_out == $past(fall_word)));

endmodule

// File: rtl/ddr_lane_formatter.sv
`timescale 1ns/1ps
// Module: ddr_lane_formatter (top)
// Dual-channel DDR lane formatter. It captures A/B samples at each period
// boundary, maps them to lanes in the selected mode, and drives the lanes
// plus a forwarded clock at double data rate.
// Assumes clk runs at twice the sample rate; reset is synchronous, active low.
module ddr_lane_formatter
    import ddr_fmt_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_sel,
    input  logic [SAMPLE_W-1:0] samp_a,
    input  logic [SAMPLE_W-1:0] samp_b,
    output logic [SAMPLE_W-1:0] rise_word,
    output logic [SAMPLE_W-1:0] fall_word,
    output logic                dco,
    output logic [SAMPLE_W-1:0] lane_out
);

    localparam int LANES = SAMPLE_W;

    logic                cap_en;
    logic                first_half;
    logic [SAMPLE_W-1:0] a_q, b_q;
    map_mode_e           mode_q;

    ddr_phase_ctrl u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .first_half (first_half)
    );

    sample_capture #(.SAMPLE_W(SAMPLE_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .samp_a   (samp_a),
        .samp_b   (samp_b),
        .mode_sel (mode_sel),
        .a_q      (a_q),
        .b_q      (b_q),
        .mode_q   (mode_q)
    );

    lane_mapper #(.SAMPLE_W(SAMPLE_W)) u_mapper (
        .a_q       (a_q),
        .b_q       (b_q),
        .mode_q    (mode_q),
        .rise_word (rise_word),
        .fall_word (fall_word)
    );

    ddr_lane_mux #(.LANES(LANES)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_half (first_half),
        .rise_word  (rise_word),
        .fall_word  (fall_word),
        .lane_out   (lane_out),
        .dco        (dco)
    );

endmodule

// File: tb/ddr_lane_formatter_bench.sv
`timescale 1ns/1ps
module ddr_lane_formatter_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_sel;
    logic [11:0] samp_a, samp_b;
    logic [11:0] rise_word, fall_word, lane_out;
    logic        dco;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [11:0] prev_fall;

    always #2.5 clk = ~clk;

    ddr_lane_formatter u_ddr_lane_formatter (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .samp_a    (samp_a),
        .samp_b    (samp_b),
        .rise_word (rise_word),
        .fall_word (fall_word),
        .dco       (dco),
        .lane_out  (lane_out)
    );

    // Expected {rise, fall} computed from R2/R3.
    function automatic logic [23:0] model_words(input logic [11:0] a, input logic [11:0] b,
                                                input logic m);
        logic [11:0] r, f;
        for (int n = 0; n < 12; n++) begin
            if (!m) begin
                r[n] = a[n];
                f[n] = b[n];
            end
        end
        if (m) begin
            for (int k = 0; k < 6; k++) begin
                r[k]   = a[2*k];
                f[k]   = a[2*k+1];
                r[6+k] = b[2*k];
                f[6+k] = b[2*k+1];
            end
        end
        return {r, f};
    endfunction

    task automatic check(input string what, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %03h expected %03h", what, act, exp);
        end
    endtask

    // One period: capture, then first phase. The second phase is checked
    // with the next capture.
    task automatic send(input logic [11:0] a, input logic [11:0] b, input logic m);
        logic [23:0] w;
        w = model_words(a, b, m);
        samp_a = a; samp_b = b; mode_sel = m;
        @(posedge clk); @(negedge clk);
        check("R6 fall lane of previous period", lane_out, prev_fall);
        check("R5 dco low after capture", {11'd0, dco}, 12'd0);
        check(m ? "R3 split rise word" : "R2 shared rise word", rise_word, w[23:12]);
        check(m ? "R3 split fall word" : "R2 shared fall word", fall_word, w[11:0]);
        // scrambled inputs on a non-capture edge must be ignored (R4, R7)
        samp_a = 12'($urandom); samp_b = 12'($urandom); mode_sel = ~m;
        @(posedge clk); @(negedge clk);
        check("R5 dco high in first phase", {11'd0, dco}, 12'd1);
        check("R6 rise lane", lane_out, w[23:12]);
        check("R4 rise word held off boundary", rise_word, w[23:12]);
        check("R7 fall word keeps mapping", fall_word, w[11:0]);
        prev_fall = w[11:0];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        logic m;
        void'($urandom(32'd1234));
        rst_n = 1'b0; mode_sel = 1'b1; samp_a = 12'hFFF; samp_b = 12'hABC;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset rise word", rise_word, 12'd0);
        check("R1 reset fall word", fall_word, 12'd0);
        check("R1 reset lanes", lane_out, 12'd0);
        check("R1 reset dco", {11'd0, dco}, 12'd0);
        rst_n = 1'b1;
        prev_fall = 12'd0;
        // directed corners
        send(12'hFFF, 12'h000, 1'b0);
        send(12'h000, 12'hFFF, 1'b0);
        send(12'hAAA, 12'h555, 1'b1);
        send(12'h555, 12'hAAA, 1'b1);
        send(12'h001, 12'h800, 1'b1);
        send(12'h800, 12'h001, 1'b0);
        send(12'hFFF, 12'h000, 1'b1);
        send(12'h123, 12'hFED, 1'b0);
        // random, with the mode held for short runs
        m = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(3) == 0) m = ~m;
            send(12'($urandom), 12'($urandom), m);
        end
        @(posedge clk); @(negedge clk);
        check("R6 final fall lane", lane_out, prev_fall);
        check("R5 final dco low", {11'd0, dco}, 12'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule